// File: doc/BRIEF.md
# Converter Result Holding Stage with Active-Low Ready

This block sits between the decimation filter of a sampling converter and the serial port a host uses to fetch results. A finished conversion arrives as a one-cycle pulse with a 24-bit word. The block keeps one unread result in an output word register and can keep one more in a single-word spare slot. It drives an active-low ready line that tells the host a result is waiting. The host reports when it starts shifting a result out and when it has finished, and each report is a one-cycle strobe.

When the host is slow, the block decides which result survives. If no read starts soon enough, a newer result replaces the one waiting in the output register. If a read runs long, the spare slot keeps only the newest result. Each lost result raises a one-cycle loss flag. After the ready line has risen, it stays high for a minimum number of cycles before it can fall again.

The block also keeps the 24-bit control word and watches byte-wise writes to it. A write that touches either of the two upper bytes means the filter or the operating mode may have changed. Such a write drops every held result, forces the ready line high, and raises a recalibration request if the new mode code selects a calibration. The request holds off new results until a calibration-finished strobe arrives. A write to the lowest byte alone leaves the results, the ready line and the request untouched.

Top module: `adc_result_stage`

## Requirements
- R1: A synchronous active-high reset sets `drdy_n` to 1 and sets `dout`, `lost`, `recal_req` and `cfg_q` to 0. It also empties the output register and the spare slot.
- R2: A result that arrives while the output register is empty appears on `dout` at the next clock edge. `drdy_n` goes to 0 at that same edge, provided `drdy_n` has already been high for at least MIN_HIGH cycles.
- R3: `rd_start` is accepted only while `drdy_n` is 0, and is ignored otherwise. The next `rd_done` after an accepted start drives `drdy_n` to 1 at the next edge. If the spare slot is empty, that `rd_done` also leaves the output register empty.
- R4: A new result can arrive while the output register is occupied, no read has started and the spare slot is empty. If `drdy_n` has been 0 for more than START_WIN cycles, the new result replaces `dout` and `lost` pulses for one cycle. If it has been 0 for START_WIN cycles or fewer, the new result goes into the spare slot instead.
- R5: A new result that is not taken by R2 or R4 goes into the spare slot when the slot is empty. When the slot is full, the new result replaces the stored word, the older word is discarded and `lost` pulses for one cycle.
- R6: When a read completes while the spare slot is full, the stored word moves to `dout` at the same edge and `drdy_n` goes to 1.
- R7: Once `drdy_n` rises, it stays at 1 for at least MIN_HIGH clock cycles before it can fall again.
- R8: When `rd_done` and a new result arrive in the same cycle, the read is handled first. The new result then takes the freed place: the output register if the spare slot was empty, or the spare slot if the spare word moved up. No result is lost in either case.
- R9: `cfg_be[k]` writes `cfg_wdata[8k+7:8k]` into `cfg_q`. A write whose only enable is `cfg_be[0]` changes neither `drdy_n` nor `recal_req`.
- R10: A write with `cfg_be[1]` or `cfg_be[2]` set empties both result stores and drives `drdy_n` to 1 at the next edge. If the mode field `cfg_q[22:20]` after the write holds a code from 1 to 4, `recal_req` becomes 1. Codes 0 and 5 to 7 are normal modes.
- R11: While `recal_req` is 1, new results are ignored and `drdy_n` stays at 1. A `cal_done` pulse clears `recal_req`, and the first result after that is accepted under R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_done | input | 1 | One-cycle pulse: a conversion result is on `conv_data` |
| conv_data | input | 24 | Finished conversion result |
| rd_start | input | 1 | Host has begun shifting out the output register |
| rd_done | input | 1 | Host has finished shifting out the output register |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_be | input | 3 | Byte enables for the control write; bit k selects bits 8k+7:8k |
| cfg_wdata | input | 24 | Control write data |
| cal_done | input | 1 | One-cycle pulse: calibration has finished |
| drdy_n | output | 1 | Result ready, active low |
| dout | output | 24 | Output word register |
| lost | output | 1 | One-cycle pulse: a result was overwritten or discarded |
| recal_req | output | 1 | Recalibration requested and not yet finished |
| cfg_q | output | 24 | Current control word |

## Verification
Completing a read and taking in a new conversion can fall on the same clock edge. If the wrong one wins, a result silently disappears or is shown twice. The bench drives `rd_done` and `conv_done` together in two states: with the spare slot full and with it empty. It then reads back every word through later host reads. The pass condition is that both the old spare word and the new result appear on `dout` in arrival order, with `lost` staying 0. In the empty-slot case the bench also checks that `drdy_n` stays high for exactly the minimum time before the new word is offered.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;

  // Mode field inside the control word (upper byte, bits 22:20)
  localparam int unsigned MODE_LSB = 20;
  localparam int unsigned MODE_W   = 3;

  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t CAL_FIRST = 3'd1;
  localparam mode_t CAL_LAST  = 3'd4;

  function automatic logic is_cal_mode(input mode_t m);
    return (m >= CAL_FIRST) && (m <= CAL_LAST);
  endfunction

endpackage

// File: rtl/adc_rb_satcnt.sv
module adc_rb_satcnt #(
  parameter int unsigned MAX      = 15,
  parameter bit          RST_FULL = 1'b0,
  localparam int unsigned W       = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = W'(MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= RST_FULL ? TOP : '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (cnt != TOP) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/adc_rb_ctrl.sv
module adc_rb_ctrl
  import adc_rb_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  localparam int unsigned BYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [BYTES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cal_done,
  output logic [DATA_W-1:0] cfg_q,
  output logic              recal_q,
  output logic              flush
);

  logic [DATA_W-1:0] merged;
  logic              cal_hit;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign merged[8*b +: 8] = (wr && be[b]) ? wdata[8*b +: 8] : cfg_q[8*b +: 8];
  end

  // Any upper-byte write may have changed the filter or mode
  assign flush   = wr && (|be[BYTES-1:1]);
  assign cal_hit = flush && is_cal_mode(merged[MODE_LSB +: MODE_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      recal_q <= 1'b0;
    end else begin
      cfg_q <= merged;
      if (cal_hit) begin
        recal_q <= 1'b1;
      end else if (cal_done) begin
        recal_q <= 1'b0;
      end
    end
  end

  // R9
  gain_only_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && be == BYTES'(1) && !cal_done) |=> (recal_q == $past(recal_q)));

endmodule

// File: rtl/adc_rb_slots.sv
module adc_rb_slots #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_in,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              rd_start,
  input  logic              rd_done,
  input  logic              ready_low,
  input  logic              window_expired,
  input  logic              flush,
  output logic [DATA_W-1:0] out_data_q,
  output logic              out_valid_q,
  output logic              out_valid_nxt,
  output logic              restart,
  output logic              read_done,
  output logic              lost_q
);

  logic              hold_valid_q, reading_q;
  logic [DATA_W-1:0] hold_data_q;
  logic              hv, rd, lost_d;
  logic [DATA_W-1:0] od, hd;

  assign read_done = rd_done && reading_q && !flush;

  always_comb begin
    out_valid_nxt = out_valid_q;
    od            = out_data_q;
    hv            = hold_valid_q;
    hd            = hold_data_q;
    rd            = reading_q;
    restart       = 1'b0;
    lost_d        = 1'b0;
    if (flush) begin
      out_valid_nxt = 1'b0;
      hv            = 1'b0;
      rd            = 1'b0;
    end else begin
      // The read side is served before a new result is placed
      if (read_done) begin
        rd = 1'b0;
        if (hv) begin
          od      = hd;
          hv      = 1'b0;
          restart = 1'b1;
        end else begin
          out_valid_nxt = 1'b0;
        end
      end else if (rd_start && ready_low && out_valid_q && !reading_q) begin
        rd = 1'b1;
      end
      if (conv_in) begin
        if (!out_valid_nxt) begin
          out_valid_nxt = 1'b1;
          od            = conv_data;
          restart       = 1'b1;
        end else if (!rd && window_expired && !hv && !restart) begin
          od      = conv_data;
          restart = 1'b1;
          lost_d  = 1'b1;
        end else if (!hv) begin
          hv = 1'b1;
          hd = conv_data;
        end else begin
          hd     = conv_data;
          lost_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q  <= 1'b0;
      out_data_q   <= '0;
      hold_valid_q <= 1'b0;
      hold_data_q  <= '0;
      reading_q    <= 1'b0;
      lost_q       <= 1'b0;
    end else begin
      out_valid_q  <= out_valid_nxt;
      out_data_q   <= od;
      hold_valid_q <= hv;
      hold_data_q  <= hd;
      reading_q    <= rd;
      lost_q       <= lost_d;
    end
  end

  // R5
  hold_needs_out_chk: assert property (@(posedge clk) disable iff (rst)
    hold_valid_q |-> out_valid_q);

  // R4
  lost_source_chk: assert property (@(posedge clk) disable iff (rst)
    lost_q |-> $past(conv_in));

endmodule

// File: rtl/adc_result_stage.sv
module adc_result_stage #(
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned START_WIN = 64,
  parameter int unsigned MIN_HIGH  = 8,
  localparam int unsigned BYTES    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              rd_start,
  input  logic              rd_done,
  input  logic              cfg_wr,
  input  logic [BYTES-1:0]  cfg_be,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              cal_done,
  output logic              drdy_n,
  output logic [DATA_W-1:0] dout,
  output logic              lost,
  output logic              recal_req,
  output logic [DATA_W-1:0] cfg_q
);

  localparam int unsigned AGE_W = $clog2(START_WIN + 1);
  localparam int unsigned HI_W  = $clog2(MIN_HIGH + 1);
  localparam logic [HI_W-1:0]  HI_NEED = HI_W'(MIN_HIGH - 1);
  localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(START_WIN);

  logic              drdy_n_q, drdy_d;
  logic              flush, recal_q;
  logic              out_valid_q, out_valid_nxt, restart, read_done;
  logic [AGE_W-1:0]  age_cnt;
  logic [HI_W-1:0]   hi_cnt;
  logic              hi_ok, window_expired;

  adc_rb_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr       (cfg_wr),
    .be       (cfg_be),
    .wdata    (cfg_wdata),
    .cal_done (cal_done),
    .cfg_q    (cfg_q),
    .recal_q  (recal_q),
    .flush    (flush)
  );

  adc_rb_slots #(.DATA_W(DATA_W)) u_slots (
    .clk            (clk),
    .rst            (rst),
    .conv_in        (conv_done && !recal_q),
    .conv_data      (conv_data),
    .rd_start       (rd_start),
    .rd_done        (rd_done),
    .ready_low      (!drdy_n_q),
    .window_expired (window_expired),
    .flush          (flush),
    .out_data_q     (dout),
    .out_valid_q    (out_valid_q),
    .out_valid_nxt  (out_valid_nxt),
    .restart        (restart),
    .read_done      (read_done),
    .lost_q         (lost)
  );

  // Cycles the ready line has been high, saturating
  adc_rb_satcnt #(.MAX(MIN_HIGH), .RST_FULL(1'b1)) u_hi_cnt (
    .clk (clk),
    .rst (rst),
    .clr (!drdy_n_q),
    .cnt (hi_cnt)
  );

  // Cycles since the ready line fell for the current word
  adc_rb_satcnt #(.MAX(START_WIN), .RST_FULL(1'b0)) u_age_cnt (
    .clk (clk),
    .rst (rst),
    .clr (drdy_n_q || drdy_d || restart),
    .cnt (age_cnt)
  );

  assign hi_ok          = (hi_cnt >= HI_NEED);
  assign window_expired = (age_cnt == AGE_TOP);

  always_comb begin
    drdy_d = 1'b0;
    if (!out_valid_nxt || flush || read_done) begin
      drdy_d = 1'b1;
    end else if (drdy_n_q && !hi_ok) begin
      drdy_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drdy_n_q <= 1'b1;
    end else begin
      drdy_n_q <= drdy_d;
    end
  end

  assign drdy_n    = drdy_n_q;
  assign recal_req = recal_q;

  // R2
  ready_has_word_chk: assert property (@(posedge clk) disable iff (rst)
    !drdy_n_q |-> out_valid_q);

  // R3
  read_end_raises_chk: assert property (@(posedge clk) disable iff (rst)
    read_done |=> drdy_n_q);

  // R7
  min_high_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(drdy_n_q) |-> ($past(hi_cnt) >= HI_NEED));

  // R10
  upper_write_raises_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> drdy_n_q);

  // R11
  recal_holds_high_chk: assert property (@(posedge clk) disable iff (rst)
    recal_q |-> drdy_n_q);

endmodule

// File: tb/tb_adc_result_stage.sv
module tb_adc_result_stage;

  localparam int unsigned DW  = 24;
  localparam int unsigned WIN = 6;
  localparam int unsigned MH  = 3;
  localparam int unsigned NV  = 35;

  typedef struct packed {
    logic          conv;
    logic [DW-1:0] data;
    logic          rs;
    logic          rd;
    logic          e_drdy;
    logic [DW-1:0] e_dout;
    logic          e_lost;
    logic [3:0]    req;
  } vec_t;

  // conv, data, rd_start, rd_done | expected drdy_n, dout, lost | requirement
  localparam vec_t TBL [NV] = '{
    '{1'b1, 24'h111111, 1'b0, 1'b0, 1'b0, 24'h111111, 1'b0, 4'd2},  // R2 fresh word
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 24'h111111, 1'b0, 4'd2},
    '{1'b0, 24'h0,      1'b1, 1'b0, 1'b0, 24'h111111, 1'b0, 4'd3},  // R3 start accepted
    '{1'b1, 24'h222222, 1'b0, 1'b0, 1'b0, 24'h111111, 1'b0, 4'd5},  // R5 into spare
    '{1'b0, 24'h0,      1'b0, 1'b1, 1'b1, 24'h222222, 1'b0, 4'd6},  // R6 spare moves up
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b1, 24'h222222, 1'b0, 4'd7},  // R7
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b1, 24'h222222, 1'b0, 4'd7},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 24'h222222, 1'b0, 4'd7},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 24'h222222, 1'b0, 4'd4},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 24'h222222, 1'b0, 4'd4},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 24'h222222, 1'b0, 4'd4},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 24'h222222, 1'b0, 4'd4},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 24'h222222, 1'b0, 4'd4},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 24'h222222, 1'b0, 4'd4},
    '{1'b1, 24'h333333, 1'b0, 1'b0, 1'b0, 24'h333333, 1'b1, 4'd4},  // R4 overwrite
    '{1'b0, 24'h0,      1'b1, 1'b0, 1'b0, 24'h333333, 1'b0, 4'd3},
    '{1'b1, 24'h444444, 1'b0, 1'b0, 1'b0, 24'h333333, 1'b0, 4'd5},
    '{1'b1, 24'h555555, 1'b0, 1'b0, 1'b0, 24'h333333, 1'b1, 4'd5},  // R5 spare replaced
    '{1'b0, 24'h0,      1'b0, 1'b1, 1'b1, 24'h555555, 1'b0, 4'd6},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b1, 24'h555555, 1'b0, 4'd7},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b1, 24'h555555, 1'b0, 4'd7},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 24'h555555, 1'b0, 4'd7},
    '{1'b0, 24'h0,      1'b1, 1'b0, 1'b0, 24'h555555, 1'b0, 4'd3},
    '{1'b0, 24'h0,      1'b0, 1'b1, 1'b1, 24'h555555, 1'b0, 4'd3},  // R3 read ends, empty
    '{1'b1, 24'h666666, 1'b0, 1'b0, 1'b1, 24'h666666, 1'b0, 4'd7},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b1, 24'h666666, 1'b0, 4'd7},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 24'h666666, 1'b0, 4'd7},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 24'h666666, 1'b0, 4'd4},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 24'h666666, 1'b0, 4'd4},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 24'h666666, 1'b0, 4'd4},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 24'h666666, 1'b0, 4'd4},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 24'h666666, 1'b0, 4'd4},
    '{1'b1, 24'h777777, 1'b0, 1'b0, 1'b0, 24'h666666, 1'b0, 4'd4},  // R4 boundary: spare
    '{1'b0, 24'h0,      1'b1, 1'b0, 1'b0, 24'h666666, 1'b0, 4'd3},
    '{1'b0, 24'h0,      1'b0, 1'b1, 1'b1, 24'h777777, 1'b0, 4'd6}
  };

  logic          clk = 1'b0;
  logic          rst, conv_done, rd_start, rd_done, cfg_wr, cal_done;
  logic [DW-1:0] conv_data, cfg_wdata;
  logic [2:0]    cfg_be;
  logic          drdy_n, lost, recal_req;
  logic [DW-1:0] dout, cfg_q;

  int n_checks = 0;
  int n_err    = 0;

  always #5 clk = ~clk;

  adc_result_stage #(.DATA_W(DW), .START_WIN(WIN), .MIN_HIGH(MH)) dut (
    .clk(clk), .rst(rst), .conv_done(conv_done), .conv_data(conv_data),
    .rd_start(rd_start), .rd_done(rd_done), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cal_done(cal_done), .drdy_n(drdy_n), .dout(dout),
    .lost(lost), .recal_req(recal_req), .cfg_q(cfg_q)
  );

  task automatic idle_in();
    conv_done = 1'b0; conv_data = '0; rd_start = 1'b0; rd_done = 1'b0;
    cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0; cal_done = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic [DW-1:0] d, input logic rs, input logic rd);
    conv_done = c; conv_data = d; rd_start = rs; rd_done = rd;
    tick();
    idle_in();
  endtask

  task automatic cfg_write(input logic [2:0] be, input logic [DW-1:0] d);
    cfg_wr = 1'b1; cfg_be = be; cfg_wdata = d;
    tick();
    idle_in();
  endtask

  task automatic wait_low(input string what);
    for (int k = 0; k < 20 && drdy_n; k++) tick();
    check(what, 32'(drdy_n), 32'd0);
  endtask

  initial begin
    #(10 * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    idle_in();
    rst = 1'b1;
    tick(); tick();
    // R1 reset state
    check("R1 drdy_n after reset", 32'(drdy_n), 32'd1);
    check("R1 dout after reset", 32'(dout), 32'd0);
    check("R1 lost after reset", 32'(lost), 32'd0);
    check("R1 recal_req after reset", 32'(recal_req), 32'd0);
    check("R1 cfg_q after reset", 32'(cfg_q), 32'd0);
    rst = 1'b0;
    tick();
    // R3: a start while not ready is ignored, so a following done changes nothing
    step(1'b0, '0, 1'b1, 1'b0);
    step(1'b0, '0, 1'b0, 1'b1);
    check("R3 stray strobes keep drdy_n", 32'(drdy_n), 32'd1);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].conv, TBL[i].data, TBL[i].rs, TBL[i].rd);
      check($sformatf("R%0d row %0d drdy_n", TBL[i].req, i), 32'(drdy_n), 32'(TBL[i].e_drdy));
      check($sformatf("R%0d row %0d dout", TBL[i].req, i), 32'(dout), 32'(TBL[i].e_dout));
      check($sformatf("R%0d row %0d lost", TBL[i].req, i), 32'(lost), 32'(TBL[i].e_lost));
    end

    // R8: read end and new result together, spare slot full
    wait_low("R8 ready before test");
    step(1'b0, '0, 1'b1, 1'b0);
    step(1'b1, 24'hA0A0A0, 1'b0, 1'b0);
    step(1'b1, 24'hB1B1B1, 1'b0, 1'b1);
    check("R8 full slot drdy_n", 32'(drdy_n), 32'd1);
    check("R8 full slot dout", 32'(dout), 32'hA0A0A0);
    check("R8 full slot lost", 32'(lost), 32'd0);
    wait_low("R8 ready for spare word");
    step(1'b0, '0, 1'b1, 1'b0);
    step(1'b0, '0, 1'b0, 1'b1);
    check("R8 new word kept", 32'(dout), 32'hB1B1B1);

    // R8 with empty spare slot, plus R7 exact high time
    wait_low("R8 ready empty slot");
    step(1'b0, '0, 1'b1, 1'b0);
    step(1'b1, 24'hC2C2C2, 1'b0, 1'b1);
    check("R8 empty slot dout", 32'(dout), 32'hC2C2C2);
    check("R8 empty slot lost", 32'(lost), 32'd0);
    check("R7 high cycle 1", 32'(drdy_n), 32'd1);
    step(1'b0, '0, 1'b0, 1'b0);
    check("R7 high cycle 2", 32'(drdy_n), 32'd1);
    step(1'b0, '0, 1'b0, 1'b0);
    check("R7 high cycle 3", 32'(drdy_n), 32'd1);
    step(1'b0, '0, 1'b0, 1'b0);
    check("R7 falls after minimum", 32'(drdy_n), 32'd0);

    // R9: low byte only
    cfg_write(3'b001, 24'h0000AB);
    check("R9 drdy_n unchanged", 32'(drdy_n), 32'd0);
    check("R9 cfg_q low byte", 32'(cfg_q), 32'h0000AB);
    check("R9 no recal", 32'(recal_req), 32'd0);

    // R10: middle byte, normal mode
    cfg_write(3'b010, 24'h00CD00);
    check("R10 drdy_n forced high", 32'(drdy_n), 32'd1);
    check("R10 cfg_q merge", 32'(cfg_q), 32'h00CDAB);
    check("R10 normal mode no recal", 32'(recal_req), 32'd0);
    for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b0, 1'b0);
    check("R10 results flushed", 32'(drdy_n), 32'd1);

    // R10/R11: upper byte selects calibration code 1
    cfg_write(3'b100, 24'h100000);
    check("R10 cal mode recal", 32'(recal_req), 32'd1);
    check("R10 cfg_q upper", 32'(cfg_q), 32'h10CDAB);
    step(1'b1, 24'hABCDEF, 1'b0, 1'b0);
    check("R11 result ignored dout", 32'(dout), 32'hC2C2C2);
    check("R11 result ignored drdy_n", 32'(drdy_n), 32'd1);
    cal_done = 1'b1;
    tick();
    idle_in();
    check("R11 cal_done clears", 32'(recal_req), 32'd0);
    step(1'b1, 24'h13579B, 1'b0, 1'b0);
    check("R11 first result after cal", 32'(dout), 32'h13579B);
    check("R11 ready after cal", 32'(drdy_n), 32'd0);

    // R10: mode code 5 is a normal mode
    cfg_write(3'b100, 24'h500000);
    check("R10 code 5 no recal", 32'(recal_req), 32'd0);
    check("R10 code 5 drdy_n high", 32'(drdy_n), 32'd1);

    // R1: reset in the middle of activity
    cfg_write(3'b100, 24'h200000);
    check("R10 code 2 recal", 32'(recal_req), 32'd1);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R1 mid reset recal", 32'(recal_req), 32'd0);
    check("R1 mid reset dout", 32'(dout), 32'd0);
    check("R1 mid reset cfg_q", 32'(cfg_q), 32'd0);
    check("R1 mid reset drdy_n", 32'(drdy_n), 32'd1);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule